// File: doc/BRIEF.md
# Sleep Mode Clock Gating Controller

This block decides when a small microcontroller core goes to sleep, which clock domains stay alive while it sleeps, and how it comes back. Software writes a control byte holding a sleep-enable bit and a two-bit mode field. A pulse on the sleep strobe, issued when the core executes its sleep instruction, moves the block into one of three low-power modes. Each mode switches off a different set of domain clock enables (CPU, flash, I/O, ADC) and, in the deepest mode, the main oscillator as well.

While asleep, the block watches a vector of wake flags and a reset-wake input. Each mode accepts a different subset of the wake flags. When the main oscillator has been stopped, the block asks an external delay timer for a start-up interval and waits for it to finish. Every wake then holds the CPU halted, with its clocks running, for a fixed number of cycles. After a wake caused by a reset, the block signals that the core must restart from its reset vector. Entry into a light mode can also fire a single-cycle ADC conversion start.

Top module: `slpctl`

## Requirements
- R1: The control byte holds sleep enable in bit 5 and the mode in bits 4..3 (00 idle, 01 ADC quiet, 10 power-down, 11 reserved). A write stores those three bits. A read returns them and returns zero in every other bit, including reserved bit 2.
- R2: A sleep strobe while sleep enable is 0 has no effect: the CPU is not halted and every clock enable stays 1.
- R3: In idle mode the CPU and flash enables are 0, and the I/O, ADC and oscillator enables are 1.
- R4: In ADC quiet mode the CPU, flash and I/O enables are 0, and the ADC and oscillator enables are 1.
- R5: In power-down mode every domain enable and the oscillator enable are 0.
- R6: A sleep strobe with mode 11 has no effect, and the core stays awake.
- R7: Entering idle or ADC quiet mode while adc_enabled is 1 pulses adc_start for exactly one cycle, in the first sleeping cycle. Entering power-down never pulses it.
- R8: wake_src bit positions are: 0 external interrupt pin, 1 pin change, 2 NVM ready, 3 ADC complete, 4 watchdog interrupt, 5 other I/O interrupt. Idle wakes on any bit. ADC quiet wakes on bits 1 to 4, and on bit 0 only if extint_level is 1. Power-down wakes on bit 1, and on bit 0 only if extint_level is 1. Any other flag leaves the core asleep with its enables unchanged.
- R9: rst_wake wakes the core from every mode. After that wake, wake_reset pulses for one cycle in the first cycle that cpu_halt is 0. It stays 0 after a wake caused by an interrupt.
- R10: A wake from power-down sets the oscillator enable to 1 and pulses startup_req for one cycle. All domain enables stay 0 until startup_done is seen.
- R11: After a wake, and after start-up if one was needed, cpu_halt stays 1 for exactly HALT_CYC (default 4) cycles with every enable at 1, then drops to 0.
- R12: After reset the core is awake: all enables are 1, cpu_halt is 0, and the control byte reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Undivided master clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the control byte |
| reg_wdata | input | 8 | Write data for the control byte |
| reg_rdata | output | 8 | Read value of the control byte |
| sleep_req | input | 1 | One-cycle pulse from the sleep instruction |
| adc_enabled | input | 1 | ADC is switched on |
| extint_level | input | 1 | External interrupt pin is set to level sensing |
| wake_src | input | 6 | Pending enabled interrupt flags, one per source |
| rst_wake | input | 1 | External, watchdog or brown-out reset request |
| startup_done | input | 1 | Delay timer has finished the start-up interval |
| clk_en_cpu | output | 1 | CPU clock enable |
| clk_en_flash | output | 1 | Flash clock enable |
| clk_en_io | output | 1 | I/O clock enable |
| clk_en_adc | output | 1 | ADC clock enable |
| osc_en | output | 1 | Main oscillator enable |
| startup_req | output | 1 | One-cycle request to start the delay timer |
| adc_start | output | 1 | One-cycle ADC auto-start pulse |
| cpu_halt | output | 1 | CPU is held and must not fetch |
| wake_reset | output | 1 | One-cycle pulse: resume from the reset vector |

## Verification
The assertions check these rules on every cycle:
- the write-then-read behaviour of the control byte;
- that a strobe without sleep enable, or with the reserved mode, leaves the core awake;
- that a stopped oscillator means every domain enable is off;
- that adc_start and startup_req appear only with the matching enable pattern;
- that every halt ends after exactly HALT_CYC cycles with all clocks running.

Only the bench scenarios can show that each mode accepts its own set of wake flags and rejects the others. The same holds for the effect of level sensing on the external pin, for the wait on the start-up handshake, and for telling a reset wake from an interrupt wake.

// File: rtl/slpctl_pkg.sv
package slpctl_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE  = 2'b00,
        MODE_QUIET = 2'b01,
        MODE_DEEP  = 2'b10,
        MODE_RSVD  = 2'b11
    } slp_mode_e;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_DOZE,
        ST_WARM,
        ST_HOLD
    } slp_state_e;

    // Positions in the control byte that software relies on.
    localparam int BIT_SE      = 5;
    localparam int BIT_MODE_HI = 4;
    localparam int BIT_MODE_LO = 3;

    // Positions in the wake flag vector.
    localparam int WK_N      = 6;
    localparam int WK_EXTINT = 0;
    localparam int WK_PINCHG = 1;
    localparam int WK_NVM    = 2;
    localparam int WK_ADC    = 3;
    localparam int WK_WDOG   = 4;
    localparam int WK_IO     = 5;

    typedef struct packed {
        logic cpu;
        logic flash;
        logic io;
        logic adc;
        logic osc;
    } dom_en_t;

    localparam dom_en_t DOM_ALL_ON = '{cpu: 1'b1, flash: 1'b1, io: 1'b1, adc: 1'b1, osc: 1'b1};
    localparam dom_en_t DOM_OSC_ON = '{cpu: 1'b0, flash: 1'b0, io: 1'b0, adc: 1'b0, osc: 1'b1};

    // Domains left running while asleep in a given mode.
    function automatic dom_en_t dom_for_mode(slp_mode_e m);
        dom_en_t d;
        d = '0;
        unique case (m)
            MODE_IDLE: begin
                d.io  = 1'b1;
                d.adc = 1'b1;
                d.osc = 1'b1;
            end
            MODE_QUIET: begin
                d.adc = 1'b1;
                d.osc = 1'b1;
            end
            default: d = '0;
        endcase
        return d;
    endfunction

    // Wake flags that a given mode accepts.
    function automatic logic [WK_N-1:0] wake_mask(slp_mode_e m, logic lvl);
        logic [WK_N-1:0] k;
        k = '0;
        unique case (m)
            MODE_IDLE: k = '1;
            MODE_QUIET: begin
                k[WK_EXTINT] = lvl;
                k[WK_PINCHG] = 1'b1;
                k[WK_NVM]    = 1'b1;
                k[WK_ADC]    = 1'b1;
                k[WK_WDOG]   = 1'b1;
            end
            MODE_DEEP: begin
                k[WK_EXTINT] = lvl;
                k[WK_PINCHG] = 1'b1;
            end
            default: k = '0;
        endcase
        return k;
    endfunction

    function automatic logic mode_is_light(slp_mode_e m);
        return (m == MODE_IDLE) || (m == MODE_QUIET);
    endfunction

endpackage

// File: rtl/slpctl_ctrlreg.sv
module slpctl_ctrlreg
    import slpctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       se,
    output slp_mode_e  mode
);

    logic       se_q;
    logic [1:0] mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            se_q   <= 1'b0;
            mode_q <= 2'b00;
        end else if (reg_wr) begin
            se_q   <= reg_wdata[BIT_SE];
            mode_q <= reg_wdata[BIT_MODE_HI:BIT_MODE_LO];
        end
    end

    always_comb begin
        reg_rdata                           = '0;
        reg_rdata[BIT_SE]                   = se_q;
        reg_rdata[BIT_MODE_HI:BIT_MODE_LO]  = mode_q;
    end

    assign se   = se_q;
    assign mode = slp_mode_e'(mode_q);

endmodule

// File: rtl/slpctl_wake.sv
module slpctl_wake
    import slpctl_pkg::*;
(
    input  slp_mode_e        mode,
    input  logic             extint_level,
    input  logic [WK_N-1:0]  wake_src,
    input  logic             rst_wake,
    output logic             wake_any
);

    logic [WK_N-1:0] accepted;

    always_comb begin
        accepted = wake_src & wake_mask(mode, extint_level);
        wake_any = rst_wake | (|accepted);
    end

endmodule

// File: rtl/slpctl_fsm.sv
module slpctl_fsm
    import slpctl_pkg::*;
#(
    parameter int HALT_CYC = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sleep_req,
    input  logic       se,
    input  slp_mode_e  mode_in,
    input  logic       adc_enabled,
    input  logic       wake_any,
    input  logic       rst_wake,
    input  logic       startup_done,
    output slp_state_e state,
    output slp_mode_e  mode_q,
    output logic       adc_go,
    output logic       warm_go,
    output logic       rst_pulse
);

    localparam int CNT_W = (HALT_CYC > 1) ? $clog2(HALT_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALT_CYC - 1);

    logic [CNT_W-1:0] cnt;
    logic             rst_cause;
    logic             go_sleep;

    assign go_sleep = sleep_req && se && (mode_in != MODE_RSVD);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_RUN;
            mode_q    <= MODE_IDLE;
            cnt       <= '0;
            rst_cause <= 1'b0;
            adc_go    <= 1'b0;
            warm_go   <= 1'b0;
            rst_pulse <= 1'b0;
        end else begin
            adc_go    <= 1'b0;
            warm_go   <= 1'b0;
            rst_pulse <= 1'b0;
            unique case (state)
                ST_RUN: begin
                    if (go_sleep) begin
                        state     <= ST_DOZE;
                        mode_q    <= mode_in;
                        rst_cause <= 1'b0;
                        adc_go    <= adc_enabled && mode_is_light(mode_in);
                    end
                end
                ST_DOZE: begin
                    if (wake_any) begin
                        rst_cause <= rst_wake;
                        cnt       <= '0;
                        if (mode_q == MODE_DEEP) begin
                            state   <= ST_WARM;
                            warm_go <= 1'b1;
                        end else begin
                            state <= ST_HOLD;
                        end
                    end
                end
                ST_WARM: begin
                    if (startup_done) begin
                        state <= ST_HOLD;
                        cnt   <= '0;
                    end
                end
                ST_HOLD: begin
                    if (cnt == CNT_LAST) begin
                        state     <= ST_RUN;
                        rst_pulse <= rst_cause;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= ST_RUN;
            endcase
        end
    end

endmodule

// File: rtl/slpctl_domains.sv
module slpctl_domains
    import slpctl_pkg::*;
(
    input  slp_state_e state,
    input  slp_mode_e  mode_q,
    output dom_en_t    dom,
    output logic       halt
);

    always_comb begin
        unique case (state)
            ST_DOZE: dom = dom_for_mode(mode_q);
            ST_WARM: dom = DOM_OSC_ON;
            default: dom = DOM_ALL_ON;
        endcase
        halt = (state != ST_RUN);
    end

endmodule

// File: rtl/slpctl.sv
module slpctl
    import slpctl_pkg::*;
#(
    parameter int HALT_CYC = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    input  logic        sleep_req,
    input  logic        adc_enabled,
    input  logic        extint_level,
    input  logic [5:0]  wake_src,
    input  logic        rst_wake,
    input  logic        startup_done,
    output logic        clk_en_cpu,
    output logic        clk_en_flash,
    output logic        clk_en_io,
    output logic        clk_en_adc,
    output logic        osc_en,
    output logic        startup_req,
    output logic        adc_start,
    output logic        cpu_halt,
    output logic        wake_reset
);

    logic       se;
    slp_mode_e  mode_reg;
    slp_mode_e  mode_q;
    slp_state_e state;
    logic       wake_any;
    dom_en_t    dom;

    slpctl_ctrlreg u_reg (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .se        (se),
        .mode      (mode_reg)
    );

    slpctl_wake u_wake (
        .mode         (mode_q),
        .extint_level (extint_level),
        .wake_src     (wake_src),
        .rst_wake     (rst_wake),
        .wake_any     (wake_any)
    );

    slpctl_fsm #(.HALT_CYC(HALT_CYC)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .sleep_req    (sleep_req),
        .se           (se),
        .mode_in      (mode_reg),
        .adc_enabled  (adc_enabled),
        .wake_any     (wake_any),
        .rst_wake     (rst_wake),
        .startup_done (startup_done),
        .state        (state),
        .mode_q       (mode_q),
        .adc_go       (adc_start),
        .warm_go      (startup_req),
        .rst_pulse    (wake_reset)
    );

    slpctl_domains u_dom (
        .state  (state),
        .mode_q (mode_q),
        .dom    (dom),
        .halt   (cpu_halt)
    );

    assign clk_en_cpu   = dom.cpu;
    assign clk_en_flash = dom.flash;
    assign clk_en_io    = dom.io;
    assign clk_en_adc   = dom.adc;
    assign osc_en       = dom.osc;

endmodule

// File: rtl/slpctl_chk.sv
module slpctl_chk #(
    parameter int HALT_CYC = 4
) (
    input logic       clk,
    input logic       rst,
    input logic       reg_wr,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata,
    input logic       sleep_req,
    input logic       clk_en_cpu,
    input logic       clk_en_flash,
    input logic       clk_en_io,
    input logic       clk_en_adc,
    input logic       osc_en,
    input logic       startup_req,
    input logic       adc_start,
    input logic       cpu_halt
);

    logic [15:0] hold_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_run <= '0;
        end else if (cpu_halt && clk_en_cpu && clk_en_io && clk_en_adc && osc_en) begin
            hold_run <= hold_run + 16'd1;
        end else begin
            hold_run <= '0;
        end
    end

    a_r1_byte_write: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> (reg_rdata == ($past(reg_wdata) & 8'h38)));

    a_r2_strobe_needs_enable: assert property (@(posedge clk) disable iff (rst)
        (!cpu_halt && sleep_req && !reg_rdata[5]) |=> !cpu_halt);

    a_r6_reserved_stays_awake: assert property (@(posedge clk) disable iff (rst)
        (!cpu_halt && sleep_req && (reg_rdata[4:3] == 2'b11)) |=> !cpu_halt);

    a_r5_osc_off_all_off: assert property (@(posedge clk) disable iff (rst)
        !osc_en |-> (!clk_en_cpu && !clk_en_flash && !clk_en_io && !clk_en_adc && cpu_halt));

    a_r7_adc_start_light: assert property (@(posedge clk) disable iff (rst)
        adc_start |-> (clk_en_adc && osc_en && !clk_en_cpu && cpu_halt));

    a_r7_adc_start_single: assert property (@(posedge clk) disable iff (rst)
        adc_start |=> !adc_start);

    a_r10_warm_request: assert property (@(posedge clk) disable iff (rst)
        startup_req |-> (osc_en && !clk_en_io && !clk_en_adc && $past(!osc_en)));

    a_r11_halt_length: assert property (@(posedge clk) disable iff (rst)
        $fell(cpu_halt) |-> (hold_run == 16'(HALT_CYC)));

endmodule

bind slpctl slpctl_chk #(.HALT_CYC(HALT_CYC)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .reg_wr       (reg_wr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .sleep_req    (sleep_req),
    .clk_en_cpu   (clk_en_cpu),
    .clk_en_flash (clk_en_flash),
    .clk_en_io    (clk_en_io),
    .clk_en_adc   (clk_en_adc),
    .osc_en       (osc_en),
    .startup_req  (startup_req),
    .adc_start    (adc_start),
    .cpu_halt     (cpu_halt)
);

// File: tb/slpctl_bench.sv
module slpctl_bench;

    localparam int HALT_CYC = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       sleep_req = 1'b0;
    logic       adc_enabled = 1'b0;
    logic       extint_level = 1'b0;
    logic [5:0] wake_src = '0;
    logic       rst_wake = 1'b0;
    logic       startup_done = 1'b0;
    logic       clk_en_cpu, clk_en_flash, clk_en_io, clk_en_adc, osc_en;
    logic       startup_req, adc_start, cpu_halt, wake_reset;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    slpctl #(.HALT_CYC(HALT_CYC)) u_slpctl (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sleep_req(sleep_req), .adc_enabled(adc_enabled), .extint_level(extint_level),
        .wake_src(wake_src), .rst_wake(rst_wake), .startup_done(startup_done),
        .clk_en_cpu(clk_en_cpu), .clk_en_flash(clk_en_flash), .clk_en_io(clk_en_io),
        .clk_en_adc(clk_en_adc), .osc_en(osc_en), .startup_req(startup_req),
        .adc_start(adc_start), .cpu_halt(cpu_halt), .wake_reset(wake_reset)
    );

    function automatic logic [4:0] obs();
        return {clk_en_cpu, clk_en_flash, clk_en_io, clk_en_adc, osc_en};
    endfunction

    // {cpu, flash, io, adc, osc}
    function automatic logic [4:0] exp_dom(input logic [1:0] m);
        case (m)
            2'b00:   return 5'b00111;
            2'b01:   return 5'b00011;
            default: return 5'b00000;
        endcase
    endfunction

    function automatic string mode_tag(input logic [1:0] m);
        case (m)
            2'b00:   return "R3";
            2'b01:   return "R4";
            default: return "R5";
        endcase
    endfunction

    function automatic bit exp_hit(input logic [1:0] m, input bit lvl, input logic [5:0] v, input bit r);
        if (r) return 1'b1;
        case (m)
            2'b00:   return |v;
            2'b01:   return (v[0] & lvl) | v[1] | v[2] | v[3] | v[4];
            default: return (v[0] & lvl) | v[1];
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr_ctrl(input logic [7:0] b);
        reg_wr = 1'b1;
        reg_wdata = b;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic count_halt(input bit exp_rst);
        int n = 0;
        for (int i = 0; i < 20 && cpu_halt; i++) begin
            if (obs() == 5'b11111) n++;
            tick();
        end
        check("R11 halt cycles", 32'(n), 32'(HALT_CYC));
        check("R11 halt released", 32'(cpu_halt), 32'd0);
        check("R9 wake_reset pulse", 32'(wake_reset), 32'(exp_rst));
        tick();
        check("R9 wake_reset single", 32'(wake_reset), 32'd0);
    endtask

    task automatic sleep_cycle(input logic [1:0] m, input bit adcen, input bit lvl,
                               input logic [5:0] first_vec, input bit use_rst);
        bit hit = 0;
        bit rcause = 0;
        adc_enabled = adcen;
        extint_level = lvl;
        wr_ctrl({2'b00, 1'b1, m, 3'b000});
        sleep_req = 1'b1;
        tick();
        sleep_req = 1'b0;
        check({mode_tag(m), " sleep enables"}, 32'(obs()), 32'(exp_dom(m)));
        check({mode_tag(m), " halted"}, 32'(cpu_halt), 32'd1);
        check("R7 adc_start on entry", 32'(adc_start), 32'(adcen && (m != 2'b10)));
        for (int t = 0; t < 5 && !hit; t++) begin
            logic [5:0] v;
            v = (t == 0) ? first_vec : 6'(1 << ($urandom % 7));
            hit = exp_hit(m, lvl, v, 1'b0);
            wake_src = v;
            tick();
            wake_src = '0;
            if (t == 0) check("R7 adc_start single", 32'(adc_start), 32'd0);
            if (!hit) begin
                check("R8 rejected flag keeps sleep", 32'(obs()), 32'(exp_dom(m)));
                check("R8 rejected flag keeps halt", 32'(cpu_halt), 32'd1);
            end
        end
        if (!hit) begin
            if (use_rst) begin
                rst_wake = 1'b1;
                rcause = 1'b1;
            end else begin
                wake_src = 6'b000010;
            end
            tick();
            rst_wake = 1'b0;
            wake_src = '0;
        end
        if (m == 2'b10) begin
            check("R10 startup_req pulse", 32'(startup_req), 32'd1);
            check("R10 osc only", 32'(obs()), 32'h01);
            for (int k = 0; k < 3; k++) begin
                tick();
                check("R10 wait start-up", 32'({startup_req, obs()}), 32'h01);
            end
            startup_done = 1'b1;
            tick();
            startup_done = 1'b0;
        end
        check("R8 woke", 32'(obs()), 32'h1F);
        count_halt(rcause);
    endtask

    initial begin
        void'($urandom(32'h5EED));
        repeat (3) tick();
        rst = 1'b0;
        tick();
        check("R12 reset enables", 32'(obs()), 32'h1F);
        check("R12 reset halt", 32'(cpu_halt), 32'd0);
        check("R12 reset byte", 32'(reg_rdata), 32'd0);

        wr_ctrl(8'hFF);
        check("R1 readback masks", 32'(reg_rdata), 32'h38);
        wr_ctrl(8'h2C);
        check("R1 readback bit2 zero", 32'(reg_rdata), 32'h28);

        wr_ctrl(8'h08);
        sleep_req = 1'b1;
        tick();
        sleep_req = 1'b0;
        check("R2 no sleep without enable", 32'({cpu_halt, obs()}), 32'h1F);

        wr_ctrl(8'h38);
        sleep_req = 1'b1;
        tick();
        sleep_req = 1'b0;
        check("R6 reserved mode stays awake", 32'({cpu_halt, obs()}), 32'h1F);
        check("R6 no adc_start", 32'(adc_start), 32'd0);

        sleep_cycle(2'b00, 1'b1, 1'b0, 6'b100000, 1'b0);
        sleep_cycle(2'b01, 1'b1, 1'b0, 6'b100000, 1'b1);
        sleep_cycle(2'b01, 1'b0, 1'b0, 6'b000001, 1'b0);
        sleep_cycle(2'b01, 1'b0, 1'b1, 6'b000001, 1'b0);
        sleep_cycle(2'b10, 1'b1, 1'b0, 6'b010000, 1'b1);
        sleep_cycle(2'b10, 1'b0, 1'b0, 6'b000001, 1'b0);
        sleep_cycle(2'b10, 1'b0, 1'b1, 6'b000001, 1'b0);
        sleep_cycle(2'b10, 1'b0, 1'b0, 6'b001000, 1'b1);

        for (int i = 0; i < 40; i++) begin
            sleep_cycle(2'($urandom % 3), 1'($urandom), 1'($urandom),
                        6'(1 << ($urandom % 7)), 1'($urandom));
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired, actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule